// File: doc/BRIEF.md
# Clock-Family Change Mute Sequencer

This block steers a one-bit audio modulator safely across a switch between the 44.1 kHz and 48 kHz master-clock families. The logic has no reference oscillator of its own, so it cannot notice the change by itself. An external controller detects the change and raises a request. The block then mutes the output and waits a fixed number of timebase ticks while the oscillator is swapped and settles. After that it pulses the on-chip PLL reset, waits for the PLL to report lock, and releases mute. With the default tick of 1 ms, the settle wait is about 0.3 s and the lock allowance is 0.2 s. A normal relock takes about 0.1 s, so the output is muted for roughly 0.4 s in total.

A strap input lets a board skip the PLL reset step. In that case the sequence only mutes across the settle window. If lock does not come within the timeout, the block applies the PLL reset once more. If the second attempt also fails, it leaves the output muted until the controller sends a new request. A request that arrives while a sequence is running starts the settle wait again from the beginning.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `family_mute_seq`

## Requirements
- R1: After reset, mute_o, pll_rst_o and busy_o are all 0.
- R2: A cycle with req_i high makes mute_o and busy_o 1 from the next cycle. mute_o stays 1 until the sequence reaches its release cycle. pll_rst_o is never 1 while mute_o is 0.
- R3: The settle wait ends on the OSC_TICKS-th cycle in which tick_i is high. Cycles with tick_i low do not advance the wait.
- R4: pll_rst_o rises only after the settle wait has ended. Each pulse is high for exactly RST_CYCLES clock cycles.
- R5: When lock_i is high during the lock wait, the next cycle is a release cycle with mute_o=0 and busy_o=1. In the cycle after that, busy_o is 0.
- R6: When skip_rst_i is 1 as the settle wait ends, pll_rst_o stays 0 and the release cycle follows directly.
- R7: If LOCK_TICKS ticks pass in the lock wait without lock_i, a second reset pulse is issued once.
- R8: If the second lock wait also times out, mute_o stays 1 and busy_o goes 0 until the next req_i.
- R9: req_i during any sequence state, or during the muted hold, restarts the settle wait. The tick count is cleared and the retry is re-armed.
- R10: lock_i has no effect outside the lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Family change request from the controller (1 = request) |
| lock_i | input | 1 | PLL lock flag (1 = locked) |
| skip_rst_i | input | 1 | Strap; 1 = omit the PLL reset step |
| tick_i | input | 1 | One-cycle timebase strobe |
| mute_o | output | 1 | 1 = modulator output muted |
| pll_rst_o | output | 1 | 1 = PLL held in reset |
| busy_o | output | 1 | 1 = sequence in progress |

## Verification
The bench builds the block with OSC_TICKS=3, LOCK_TICKS=4 and RST_CYCLES=2. With these values, a full sequence that includes a retry and a final timeout takes only a few dozen cycles. The bench sweeps tick spacings of 1, 2 and 3 cycles, both strap values, and five lock behaviours: immediate lock, late lock, lock only after the retry, no lock at all, and lock held high with a mid-sequence re-request. In every cycle it compares the three outputs against a bench-side model of the requirements.

// File: rtl/family_seq_pkg.sv
package family_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_PRST   = 3'd2,
    ST_LOCKW  = 3'd3,
    ST_REL    = 3'd4,
    ST_HOLD   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/family_seq_fsm.sv
module family_seq_fsm
  import family_seq_pkg::*;
#(
  parameter int OSC_TICKS  = 300,
  parameter int LOCK_TICKS = 200,
  parameter int RST_CYCLES = 16,
  parameter int W          = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic         lock_i,
  input  logic         skip_rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] cnt,
  output logic         clr,
  output logic         inc,
  output logic         mute_o,
  output logic         pll_rst_o,
  output logic         busy_o
);
  localparam logic [W-1:0] OSC_LAST  = W'(OSC_TICKS - 1);
  localparam logic [W-1:0] LOCK_LAST = W'(LOCK_TICKS - 1);
  localparam logic [W-1:0] RST_LAST  = W'(RST_CYCLES - 1);

  seq_state_e st, st_n;
  logic retry, retry_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      retry <= 1'b0;
    end else begin
      st    <= st_n;
      retry <= retry_n;
    end
  end

  always_comb begin
    st_n    = st;
    retry_n = retry;
    clr     = 1'b0;
    inc     = 1'b0;
    if (req_i) begin
      st_n    = ST_SETTLE;
      clr     = 1'b1;
      retry_n = 1'b0;
    end else begin
      unique case (st)
        ST_SETTLE: if (tick_i) begin
          if (cnt == OSC_LAST) begin
            clr  = 1'b1;
            st_n = skip_rst_i ? ST_REL : ST_PRST;
          end else inc = 1'b1;
        end
        ST_PRST: begin
          if (cnt == RST_LAST) begin
            clr  = 1'b1;
            st_n = ST_LOCKW;
          end else inc = 1'b1;
        end
        ST_LOCKW: begin
          if (lock_i) begin
            clr  = 1'b1;
            st_n = ST_REL;
          end else if (tick_i) begin
            if (cnt == LOCK_LAST) begin
              clr = 1'b1;
              if (retry) st_n = ST_HOLD;
              else begin
                st_n    = ST_PRST;
                retry_n = 1'b1;
              end
            end else inc = 1'b1;
          end
        end
        ST_REL:  st_n = ST_IDLE;
        default: ;
      endcase
    end
  end

  assign mute_o    = (st != ST_IDLE) && (st != ST_REL);
  assign pll_rst_o = (st == ST_PRST);
  assign busy_o    = (st == ST_SETTLE) || (st == ST_PRST) || (st == ST_LOCKW) || (st == ST_REL);

  // R2
  req_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (mute_o && busy_o));
  // R2
  rst_under_mute_chk: assert property (@(posedge clk) disable iff (!rst_n) pll_rst_o |-> mute_o);
  // R4
  rst_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_o) |-> ($past(st) == ST_SETTLE || $past(st) == ST_LOCKW));
  // R6
  skip_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pll_rst_o) |-> !$past(skip_rst_i));
  // R8
  hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_HOLD && !req_i) |=> (mute_o && !busy_o));
endmodule

// File: rtl/family_mute_seq.sv
module family_mute_seq #(
  parameter int OSC_TICKS  = 300,
  parameter int LOCK_TICKS = 200,
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic lock_i,
  input  logic skip_rst_i,
  input  logic tick_i,
  output logic mute_o,
  output logic pll_rst_o,
  output logic busy_o
);
  localparam int MAX_AB = (OSC_TICKS > LOCK_TICKS) ? OSC_TICKS : LOCK_TICKS;
  localparam int MAX_V  = (MAX_AB > RST_CYCLES) ? MAX_AB : RST_CYCLES;
  localparam int W      = $clog2(MAX_V + 1);

  logic [W-1:0] cnt;
  logic clr, inc;

  seq_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cnt(cnt)
  );

  family_seq_fsm #(
    .OSC_TICKS(OSC_TICKS), .LOCK_TICKS(LOCK_TICKS), .RST_CYCLES(RST_CYCLES), .W(W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
    .skip_rst_i(skip_rst_i), .tick_i(tick_i), .cnt(cnt),
    .clr(clr), .inc(inc), .mute_o(mute_o), .pll_rst_o(pll_rst_o), .busy_o(busy_o)
  );
endmodule

// File: tb/family_mute_seq_tb.sv
module family_mute_seq_tb;
  localparam int OSC = 3, LCK = 4, RSTC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, lock = 1'b0, skip = 1'b0, tick = 1'b0;
  logic mute, prst, busy;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  family_mute_seq #(.OSC_TICKS(OSC), .LOCK_TICKS(LCK), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .skip_rst_i(skip),
    .tick_i(tick), .mute_o(mute), .pll_rst_o(prst), .busy_o(busy)
  );

  // phases: 0 idle, 1 settle, 2 reset pulse, 3 lock wait, 4 release, 5 hold
  int m_ph = 0, m_n = 0;
  bit m_retry = 1'b0;

  function automatic void model_step(bit r, bit l, bit s, bit t);
    if (r) begin m_ph = 1; m_n = 0; m_retry = 0; end       // R9
    else case (m_ph)
      1: if (t) begin                                         // R3
           m_n++;
           if (m_n == OSC) begin m_n = 0; m_ph = s ? 4 : 2; end  // R6
         end
      2: begin m_n++; if (m_n == RSTC) begin m_n = 0; m_ph = 3; end end  // R4
      3: if (l) begin m_n = 0; m_ph = 4; end                  // R5, R10
         else if (t) begin
           m_n++;
           if (m_n == LCK) begin
             m_n = 0;
             if (m_retry) m_ph = 5;                           // R8
             else begin m_retry = 1; m_ph = 2; end            // R7
           end
         end
      4: m_ph = 0;
      default: ;
    endcase
  endfunction

  task automatic compare(string tag);
    bit em, ep, eb;
    em = (m_ph == 1 || m_ph == 2 || m_ph == 3 || m_ph == 5);
    ep = (m_ph == 2);
    eb = (m_ph >= 1 && m_ph <= 4);
    vecs++;
    if (mute !== em) begin errs++; $display("FAIL R2 (run %s) mute_o got %b exp %b", tag, mute, em); end
    else if (prst !== ep) begin errs++; $display("FAIL R4 (run %s) pll_rst_o got %b exp %b", tag, prst, ep); end
    else if (busy !== eb) begin errs++; $display("FAIL R5 (run %s) busy_o got %b exp %b", tag, busy, eb); end
  endtask

  task automatic step(bit r, bit l, bit s, bit t, string tag);
    @(negedge clk);
    req = r; lock = l; skip = s; tick = t;
    @(posedge clk); #1;
    model_step(r, l, s, t);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    vecs++;
    if (mute !== 1'b0 || prst !== 1'b0 || busy !== 1'b0) begin
      errs++; $display("FAIL R1 reset outputs got %b%b%b exp 000", mute, prst, busy);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 1, "R1");   // R10: lock and tick while idle change nothing
    step(0, 0, 1, 1, "R1");

    for (int s = 0; s < 2; s++)
      for (int per = 1; per <= 3; per++)
        for (int sc = 0; sc < 5; sc++) begin
          int falls = 0, since = 0, need_n, dly;
          bit prev_p = 1'b0;
          string tag;
          case (sc)
            0: begin need_n = 1; dly = 0;  tag = "R5"; end
            1: begin need_n = 1; dly = 3;  tag = "R3"; end
            2: begin need_n = 2; dly = 1;  tag = "R7"; end
            3: begin need_n = 9; dly = 0;  tag = "R8"; end
            default: begin need_n = 1; dly = 0; tag = "R9"; end
          endcase
          if (s == 1 && sc < 3) tag = "R6";
          for (int k = 0; k < 70; k++) begin
            bit r, l, t;
            r = (k == 0) || (sc == 4 && k == 5);
            t = ((k % per) == per - 1);
            if (sc == 4) l = 1'b1;       // R10: lock held high before the lock wait
            else l = (falls >= need_n) && (since >= dly);
            step(r, l, bit'(s), t, tag);
            if (prev_p && !prst) begin falls++; since = 0; end
            else if (!prst && falls > 0) since++;
            prev_p = prst;
          end
        end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errs++; $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule